// File: doc/BRIEF.md
# Epoch-Offset Seconds Clock

This block keeps a 32-bit count of seconds measured from midnight on 1 January 1904. It does not store the time directly. A free-running elapsed-seconds counter and a stored offset are added together to form the time. The elapsed counter advances on a one-cycle seconds enable. That enable comes from a prescaler elsewhere in the clock tree. Each enable also produces a one-cycle tick pulse, which an interrupt controller can latch as a periodic event. The tick period is set only by the enable, so it does not drift.

Software reaches the clock through a small byte-serial command port. A command opens with a start strobe that selects a read or a write. Zero or more argument bytes follow, and an end strobe closes the command. A read must carry no argument bytes. It returns the time as four bytes, most significant first. A write must carry exactly four argument bytes, most significant first. An accepted write rewrites the offset as the written value minus the elapsed count, so later reads continue from the written value. A command with the wrong argument count is refused and changes nothing.

During reset the offset is loaded from an input port and the elapsed count returns to zero. To convert a 1970-based seconds count to this epoch, add 2082844800. The package exports this constant for whoever drives the initial value.

Top module: `epoch_sec_clock`

## Requirements
- R1: While `rst_n` is low, the offset loads `init_offset` and the elapsed count clears. After reset, `tick`, `rsp_valid` and `req_reject` are 0, and a read with no intervening enable returns `init_offset`.
- R2: `tick` is high for exactly the one cycle after each cycle in which `sec_en` was sampled high, and is low at all other times.
- R3: Each cycle with `sec_en` high advances the time by one. A read returns the time as it stood in the cycle `req_end` was sampled.
- R4: A read (`req_op` = 0) with zero argument bytes is accepted. Starting in the cycle after `req_end`, `rsp_valid` stays high for four consecutive cycles. `rsp_data` carries bits 31:24, 23:16, 15:8 and 7:0 in that order, and `rsp_last` is high only with the fourth byte.
- R5: A read that carries any argument byte is refused. `req_reject` pulses for one cycle in the cycle after `req_end`, and no response is produced.
- R6: A write (`req_op` = 1) with exactly four argument bytes is accepted. The first byte received is bits 31:24 of the value. Later reads return the written value plus the number of enables since.
- R7: A write with any argument count other than four is refused with a one-cycle `req_reject` pulse. The time the next read returns is unchanged.
- R8: All time arithmetic wraps modulo 2^32, so an enable at 0xFFFFFFFF gives 0.
- R9: When `sec_en` is high in the same cycle that an accepted write ends, a read that follows returns exactly the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_offset | input | 32 | Offset loaded while reset is held |
| sec_en | input | 1 | One-cycle enable, once per second |
| req_start | input | 1 | Opens a command, latches `req_op` |
| req_op | input | 1 | 0 = read time, 1 = write time |
| arg_valid | input | 1 | Argument byte present |
| arg_data | input | 8 | Argument byte |
| req_end | input | 1 | Closes the command and executes it |
| rsp_valid | output | 1 | Response byte present |
| rsp_data | output | 8 | Response byte, most significant first |
| rsp_last | output | 1 | Marks the final response byte |
| req_reject | output | 1 | One-cycle pulse: command refused |
| tick | output | 1 | One-cycle seconds event |

## Verification
The tick and the refuse pulse each have one register of delay, so both are due one cycle after the edge that samples their cause. The first response byte is also due in the cycle after the `req_end` edge, and the other three bytes follow on the next three cycles. The bench drives inputs on the falling edge and samples each result on the falling edge that falls exactly that many rising edges later. It checks one cycle further that each pulse has dropped again. A write's effect is checked through the value the next read returns.

// File: rtl/esc_pkg.sv
package esc_pkg;
   typedef enum logic {
      ESC_OP_READ  = 1'b0,
      ESC_OP_WRITE = 1'b1
   } esc_op_e;

   // seconds between 1904-01-01 and 1970-01-01
   localparam logic [31:0] ESC_SHIFT_1970 = 32'd2082844800;
endpackage

// File: rtl/esc_sec_count.sv
module esc_sec_count #(
   parameter int TIME_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sec_en,
   output logic [TIME_W-1:0] elapsed,
   output logic [TIME_W-1:0] elapsed_nxt,
   output logic              tick
);
   assign elapsed_nxt = elapsed + TIME_W'(sec_en);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         elapsed <= '0;
         tick    <= 1'b0;
      end else begin
         elapsed <= elapsed_nxt;
         tick    <= sec_en;
      end
   end
endmodule

// File: rtl/esc_arg_collect.sv
module esc_arg_collect #(
   parameter int TIME_W = 32,
   parameter int BYTE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clear,
   input  logic                push,
   input  logic [BYTE_W-1:0]   din,
   output logic [TIME_W-1:0]   word,
   output logic                cnt_zero,
   output logic                cnt_full
);
   localparam int NBYTES = TIME_W / BYTE_W;
   localparam int CNT_W  = $clog2(NBYTES + 2);
   localparam logic [CNT_W-1:0] SAT = CNT_W'(NBYTES + 1);

   logic [CNT_W-1:0] cnt;

   generate
      if (NBYTES == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n)     word <= '0;
            else if (clear) word <= '0;
            else if (push)  word <= din;
         end
      end else begin : g_multi
         always_ff @(posedge clk) begin
            if (!rst_n)     word <= '0;
            else if (clear) word <= '0;
            else if (push)  word <= {word[TIME_W-BYTE_W-1:0], din};
         end
      end
   endgenerate

   // count saturates one past a full word so overlong writes are seen
   always_ff @(posedge clk) begin
      if (!rst_n)                  cnt <= '0;
      else if (clear)              cnt <= '0;
      else if (push && cnt != SAT) cnt <= cnt + 1'b1;
   end

   assign cnt_zero = (cnt == '0);
   assign cnt_full = (cnt == CNT_W'(NBYTES));
endmodule

// File: rtl/esc_rsp_serial.sv
module esc_rsp_serial #(
   parameter int TIME_W = 32,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [TIME_W-1:0] value,
   output logic              valid,
   output logic [BYTE_W-1:0] data,
   output logic              last
);
   localparam int NBYTES = TIME_W / BYTE_W;
   localparam int CNT_W  = $clog2(NBYTES + 1);

   logic [TIME_W-1:0] sreg;
   logic [CNT_W-1:0]  left;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sreg <= '0;
         left <= '0;
      end else if (load) begin
         sreg <= value;
         left <= CNT_W'(NBYTES);
      end else if (left != '0) begin
         sreg <= sreg << BYTE_W;
         left <= left - 1'b1;
      end
   end

   assign valid = (left != '0);
   assign last  = (left == CNT_W'(1));
   assign data  = sreg[TIME_W-1 -: BYTE_W];
endmodule

// File: rtl/epoch_sec_clock.sv
module epoch_sec_clock #(
   parameter int TIME_W = 32,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIME_W-1:0] init_offset,
   input  logic              sec_en,
   input  logic              req_start,
   input  logic              req_op,
   input  logic              arg_valid,
   input  logic [BYTE_W-1:0] arg_data,
   input  logic              req_end,
   output logic              rsp_valid,
   output logic [BYTE_W-1:0] rsp_data,
   output logic              rsp_last,
   output logic              req_reject,
   output logic              tick
);
   import esc_pkg::*;

   generate
      if (BYTE_W < 1 || TIME_W % BYTE_W != 0) begin : g_bad_width
         $error("TIME_W must be a whole number of BYTE_W bytes");
      end
   endgenerate

   logic [TIME_W-1:0] elapsed, elapsed_nxt, offset_q, arg_word;
   logic              cnt_zero, cnt_full, accept_rd, accept_wr;
   esc_op_e           op_q;

   esc_sec_count #(.TIME_W(TIME_W)) u_count (
      .clk(clk), .rst_n(rst_n), .sec_en(sec_en),
      .elapsed(elapsed), .elapsed_nxt(elapsed_nxt), .tick(tick)
   );

   esc_arg_collect #(.TIME_W(TIME_W), .BYTE_W(BYTE_W)) u_args (
      .clk(clk), .rst_n(rst_n), .clear(req_start), .push(arg_valid),
      .din(arg_data), .word(arg_word), .cnt_zero(cnt_zero), .cnt_full(cnt_full)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)         op_q <= ESC_OP_READ;
      else if (req_start) op_q <= esc_op_e'(req_op);
   end

   assign accept_rd = req_end && (op_q == ESC_OP_READ)  && cnt_zero;
   assign accept_wr = req_end && (op_q == ESC_OP_WRITE) && cnt_full;

   // offset is taken against the post-edge elapsed count
   always_ff @(posedge clk) begin
      if (!rst_n)         offset_q <= init_offset;
      else if (accept_wr) offset_q <= arg_word - elapsed_nxt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) req_reject <= 1'b0;
      else        req_reject <= req_end && !accept_rd && !accept_wr;
   end

   esc_rsp_serial #(.TIME_W(TIME_W), .BYTE_W(BYTE_W)) u_rsp (
      .clk(clk), .rst_n(rst_n), .load(accept_rd), .value(offset_q + elapsed),
      .valid(rsp_valid), .data(rsp_data), .last(rsp_last)
   );
endmodule

// File: rtl/esc_checker.sv
module esc_checker (
   input logic clk,
   input logic rst_n,
   input logic sec_en,
   input logic req_end,
   input logic tick,
   input logic rsp_valid,
   input logic rsp_last,
   input logic req_reject
);
   AST_TICK_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n)
      sec_en |=> tick); // R2
   AST_TICK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      tick && !sec_en |=> !tick); // R2
   AST_LAST_IN_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_last |-> rsp_valid); // R4
   AST_RSP_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_last |=> rsp_valid); // R4
   AST_RSP_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rsp_valid) |-> $past(req_end)); // R4
   AST_REJECT_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      req_reject |-> !$rose(rsp_valid)); // R5
   AST_REJECT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_reject && !req_end |=> !req_reject); // R7
endmodule

bind epoch_sec_clock esc_checker u_esc_checker (
   .clk(clk), .rst_n(rst_n), .sec_en(sec_en), .req_end(req_end), .tick(tick),
   .rsp_valid(rsp_valid), .rsp_last(rsp_last), .req_reject(req_reject)
);

// File: tb/tb_epoch_sec_clock.sv
`timescale 1ns/1ps
module tb_epoch_sec_clock;
   logic        clk = 1'b0, rst_n = 1'b0;
   logic [31:0] init_offset;
   logic        sec_en = 0, req_start = 0, req_op = 0, arg_valid = 0, req_end = 0;
   logic [7:0]  arg_data = '0;
   logic        rsp_valid, rsp_last, req_reject, tick;
   logic [7:0]  rsp_data;
   int          n_chk = 0, n_fail = 0;
   logic [31:0] model;

   epoch_sec_clock dut (.*);

   always #2.5 clk = ~clk;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] byte_of(input logic [31:0] w, input int i);
      return w[31 - 8*(i % 4) -: 8];
   endfunction

   task automatic do_sec();
      @(negedge clk) sec_en = 1;
      @(negedge clk) sec_en = 0;
      model = model + 1;
      check("R2 tick after enable", tick, 1);
      @(negedge clk);
      check("R2 tick single cycle", tick, 0);
   endtask

   // issue a command; returns at the negedge after the req_end edge
   task automatic send(input logic op, input int nargs, input logic [31:0] w, input logic with_sec);
      @(negedge clk) begin req_start = 1; req_op = op; end
      @(negedge clk) req_start = 0;
      for (int i = 0; i < nargs; i++) begin
         arg_valid = 1; arg_data = byte_of(w, i);
         @(negedge clk);
      end
      arg_valid = 0; req_end = 1; sec_en = with_sec;
      @(negedge clk) begin req_end = 0; sec_en = 0; end
      check("R2 tick with command", tick, 32'(with_sec));
   endtask

   task automatic do_read(input string req, input logic with_sec);
      logic [31:0] exp;
      exp = model;
      send(1'b0, 0, 32'h0, with_sec);
      if (with_sec) model = model + 1;
      check("R4 no reject on read", req_reject, 0);
      for (int i = 0; i < 4; i++) begin
         check("R4 rsp_valid", rsp_valid, 1);
         check(req, rsp_data, byte_of(exp, i));
         check("R4 rsp_last", rsp_last, 32'(i == 3));
         @(negedge clk);
      end
      check("R4 response ends", rsp_valid, 0);
   endtask

   task automatic do_write(input logic [31:0] w, input int nargs, input logic with_sec);
      send(1'b1, nargs, w, with_sec);
      if (nargs == 4) begin
         model = w;
         check("R6 write accepted", req_reject, 0);
      end else begin
         if (with_sec) model = model + 1;
         check("R7 bad write rejected", req_reject, 1);
         check("R7 no response", rsp_valid, 0);
      end
      @(negedge clk);
      check("R7 reject single pulse", req_reject, 0);
   endtask

   task automatic bad_read(input int nargs);
      send(1'b0, nargs, $urandom, 1'b0);
      check("R5 read with args rejected", req_reject, 1);
      check("R5 no response", rsp_valid, 0);
      @(negedge clk);
      check("R5 still no response", rsp_valid, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      init_offset = 32'd1000000000 + esc_pkg::ESC_SHIFT_1970;
      model = init_offset;
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check("R1 tick idle", tick, 0);
      check("R1 rsp idle", rsp_valid, 0);
      check("R1 reject idle", req_reject, 0);
      do_read("R1 init offset read", 1'b0);
      do_sec(); do_sec();
      do_read("R3 read after two seconds", 1'b0);
      do_write(32'h12345678, 4, 1'b0);
      do_read("R6 read after write", 1'b0);
      do_sec();
      do_read("R6 written plus one second", 1'b0);
      do_write(32'hDEADBEEF, 3, 1'b0);
      do_read("R7 short write no change", 1'b0);
      do_write(32'hDEADBEEF, 5, 1'b0);
      do_read("R7 long write no change", 1'b0);
      do_write(32'hDEADBEEF, 0, 1'b1);
      do_read("R7 empty write no change", 1'b0);
      bad_read(1);
      do_read("R5 time intact after refused read", 1'b0);
      do_write(32'hFFFFFFFF, 4, 1'b0);
      do_sec();
      do_read("R8 wrap to zero", 1'b0);
      do_write(32'hA5A5_0001, 4, 1'b1);
      do_read("R9 write with enable", 1'b0);
      do_read("R3 read snapshot with enable", 1'b1);
      do_read("R3 read after snapshot", 1'b0);
      for (int k = 0; k < 60; k++) begin
         case ($urandom % 6)
            0: do_sec();
            1: do_read("R3 random read", 1'($urandom));
            2: do_write($urandom, 4, 1'($urandom));
            3: do_write($urandom, int'($urandom % 4), 1'b0);
            4: bad_read(1 + int'($urandom % 5));
            default: do_read("R6 random read", 1'b0);
         endcase
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule